// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a host-facing command queue and a bit-level I2C engine. The host pushes 11-bit command words, each carrying one data byte plus per-entry flags for direction, stop-after and repeated-start-before. The sequencer turns them into an ordered stream of bus primitives: start, repeated start, address byte, write byte, read byte and stop. It hands these one at a time to the engine over a request/done handshake. Bytes read from the bus land in a receive FIFO that the host drains.

Addressing follows a target address input that is captured at the start of every transfer. It supports 7-bit and 10-bit modes; a 10-bit read inserts the required repeated start and a second high address byte. When the queue runs dry with no stop requested, the sequencer keeps the bus and waits with SCL held low. An enable input reaches an enable-status output only after a fixed delay. A missing acknowledge, lost arbitration or a command sent while disabled aborts the transfer, flushes both FIFOs and sets one bit per cause in a sticky abort-source output.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, both FIFO levels, en_status, activity, scl_hold, prim_req and abort_src are all zero.
- R2: en_status rises exactly EN_DLY+1 clock edges after enable rises. It falls only after the delayed enable is low and activity has been low for a cycle, so it is still high one cycle after enable drops.
- R3: Command word: [7:0] write data, [8] read, [9] stop after this byte, [10] repeated start before it. Primitive op codes are START=0, RSTART=1, ADDR=2, WRITE=3, READ=4, STOP=5. prim_byte is 0 for START, RSTART and STOP. For READ, bit 0 is 1 when the stop flag is set, meaning NACK the last byte.
- R4: With the bus idle and enabled, the head command opens a transfer with START and then the address. In 7-bit mode the address byte is {tgt[6:0], read}.
- R5: When tgt bit 12 is set, the address phase is ADDR {11110, tgt[9:8], 0} then ADDR tgt[7:0]. For a read it continues with RSTART and ADDR {11110, tgt[9:8], 1}.
- R6: Inside a transfer, a command whose restart flag is set, or whose direction differs from the current one, gets RSTART and a fresh address phase. Otherwise only its data primitive is issued.
- R7: When the FIFO is empty after a command without stop, scl_hold and activity stay high and no primitive is requested until a new command arrives.
- R8: Read bytes enter the receive FIFO in bus order. tx_level and rx_level count the stored entries.
- R9: A NACK on the address or on write data sets abort bit 0 (7-bit address), 1 (first 10-bit byte), 2 (second 10-bit byte) or 3 (data), and a STOP follows.
- R10: Arbitration lost on any primitive sets abort bit 12, and the sequencer returns to idle without a STOP.
- R11: A command pushed while en_status is low is dropped and sets abort bit 11.
- R12: Any abort empties both FIFOs. abort_src holds its bits until the next transfer starts, then clears.
- R13: Dropping enable while the bus is held issues STOP and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Requested enable |
| tgt_addr | input | 13 | Target address; bit 12 selects 10-bit mode |
| cmd_push | input | 1 | Write cmd_word into the command FIFO |
| cmd_word | input | 11 | Command word |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| tx_level | output | 4 | Command FIFO fill count |
| rx_level | output | 3 | Receive FIFO fill count |
| en_status | output | 1 | Delayed enable state |
| activity | output | 1 | A transfer owns the bus |
| scl_hold | output | 1 | Waiting for commands with SCL held low |
| abort_src | output | 13 | Sticky abort causes |
| prim_req | output | 1 | Primitive request to the bit engine |
| prim_op | output | 3 | Primitive op code |
| prim_byte | output | 8 | Primitive byte operand |
| prim_done | input | 1 | Engine completed the current primitive |
| prim_nack | input | 1 | Byte was not acknowledged |
| prim_arb_lost | input | 1 | Arbitration lost during the primitive |
| prim_rdata | input | 8 | Byte received by a READ |

## Verification
A model of the bit engine answers every request, and the bench compares the primitive stream against a queue of expected op/byte pairs. The command patterns used are:
- a 7-bit write split by an empty-queue hold, which separates holding the bus from releasing it;
- a write followed by a read with no flag, which shows that a direction change forces a restart;
- a same-direction write carrying the restart flag;
- a 10-bit write and a 10-bit two-byte read, which tell the address sequences apart.

Failures are injected as NACKs on each address stage and on data, and as arbitration loss. Each case has a distinct expected abort bit and trailing stop behaviour, and receive data left in the FIFO shows the flush.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int CMD_W   = 11;
  localparam int TGT_W   = 13;
  localparam int TEN_SEL = 12;
  localparam int ABRT_W  = 13;

  // abort cause positions
  localparam int AB_A7   = 0;
  localparam int AB_A10H = 1;
  localparam int AB_A10L = 2;
  localparam int AB_DATA = 3;
  localparam int AB_OFF  = 11;
  localparam int AB_ARB  = 12;

  typedef enum logic [2:0] {
    P_START  = 3'd0,
    P_RSTART = 3'd1,
    P_ADDR   = 3'd2,
    P_WRITE  = 3'd3,
    P_READ   = 3'd4,
    P_STOP   = 3'd5
  } prim_op_e;

  typedef struct packed {
    logic       rs;
    logic       stp;
    logic       rd;
    logic [7:0] dat;
  } cmd_t;

  // stage 0: first address byte, 1: low 10-bit byte, 2: 10-bit read header
  function automatic logic [7:0] addr_byte(input logic [TGT_W-1:0] tgt,
                                           input logic [1:0] stage,
                                           input logic rd);
    logic [7:0] b;
    case (stage)
      2'd0:    b = tgt[TEN_SEL] ? {5'b11110, tgt[9:8], 1'b0} : {tgt[6:0], rd};
      2'd1:    b = tgt[7:0];
      default: b = {5'b11110, tgt[9:8], 1'b1};
    endcase
    return b;
  endfunction

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      level <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      level <= '0;
    end else begin
      if (do_push) wr_q <= AW'(i2cs_pkg::ptr_next(int'(wr_q), DEPTH));
      if (do_pop)  rd_q <= AW'(i2cs_pkg::ptr_next(int'(rd_q), DEPTH));
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(level)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R12
endmodule

// File: rtl/i2cs_en_sync.sv
module i2cs_en_sync #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic busy,
  output logic en_status
);
  logic stage_out;

  generate
    if (DLY <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= enable;
      end
      assign stage_out = s_q;
    end else begin : g_chain
      logic [DLY-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[DLY-2:0], enable};
      end
      assign stage_out = s_q[DLY-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_status <= 1'b0;
    else if (stage_out) en_status <= 1'b1;
    else if (!busy)     en_status <= 1'b0;
  end

  AST_EN_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_status) |-> $past(!busy)); // R2
endmodule

// File: rtl/i2cs_seq_fsm.sv
module i2cs_seq_fsm
  import i2cs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                en_live,
  input  logic [TGT_W-1:0]    tgt_addr,
  input  cmd_t                head,
  input  logic                tx_has,
  input  logic                rx_full,
  input  logic                prim_done,
  input  logic                prim_nack,
  input  logic                prim_arb_lost,
  output logic                prim_req,
  output logic [2:0]          prim_op,
  output logic [7:0]          prim_byte,
  output logic                tx_pop,
  output logic                rx_push,
  output logic [ABRT_W-1:0]   abort_set,
  output logic                xfer_begin,
  output logic                busy,
  output logic                hold
);
  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_START, S_RSTART, S_A1, S_A2, S_RS10, S_A3, S_DATA, S_STOP
  } st_e;

  st_e             st_q, st_d;
  logic            rd_q, rd_d;
  logic [TGT_W-1:0] tgt_q;
  logic            ten, can_go, dir_flip, fin;

  assign ten      = tgt_q[TEN_SEL];
  assign can_go   = tx_has && !(head.rd && rx_full);
  assign dir_flip = head.rs || (head.rd != rd_q);
  assign fin      = prim_req && prim_done;
  assign busy     = (st_q != S_IDLE);
  assign hold     = (st_q == S_HOLD);
  assign tx_pop   = fin && (st_q == S_DATA);
  assign rx_push  = fin && (st_q == S_DATA) && head.rd && !prim_arb_lost;

  // primitive presented to the bit engine
  always_comb begin
    prim_req  = 1'b1;
    prim_op   = P_START;
    prim_byte = 8'h00;
    case (st_q)
      S_START:          prim_op = P_START;
      S_RSTART, S_RS10: prim_op = P_RSTART;
      S_A1: begin prim_op = P_ADDR; prim_byte = addr_byte(tgt_q, 2'd0, rd_q); end
      S_A2: begin prim_op = P_ADDR; prim_byte = addr_byte(tgt_q, 2'd1, rd_q); end
      S_A3: begin prim_op = P_ADDR; prim_byte = addr_byte(tgt_q, 2'd2, rd_q); end
      S_DATA: begin
        if (head.rd) begin
          prim_op   = P_READ;
          prim_byte = {7'd0, head.stp};
        end else begin
          prim_op   = P_WRITE;
          prim_byte = head.dat;
        end
      end
      S_STOP:  prim_op = P_STOP;
      default: prim_req = 1'b0;
    endcase
  end

  // abort causes from the completed primitive
  always_comb begin
    abort_set = '0;
    if (fin) begin
      if (prim_arb_lost) abort_set[AB_ARB] = 1'b1;
      else if (prim_nack) begin
        case (st_q)
          S_A1:    if (ten) abort_set[AB_A10H] = 1'b1; else abort_set[AB_A7] = 1'b1;
          S_A2:    abort_set[AB_A10L] = 1'b1;
          S_A3:    abort_set[AB_A10H] = 1'b1;
          S_DATA:  if (!head.rd) abort_set[AB_DATA] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    st_d       = st_q;
    rd_d       = rd_q;
    xfer_begin = 1'b0;
    case (st_q)
      S_IDLE: if (enable && en_live && can_go) begin
        st_d       = S_START;
        rd_d       = head.rd;
        xfer_begin = 1'b1;
      end
      S_HOLD: begin
        if (!enable) st_d = S_STOP;
        else if (can_go) begin
          st_d = dir_flip ? S_RSTART : S_DATA;
          rd_d = head.rd;
        end
      end
      default: if (fin) begin
        if (prim_arb_lost)   st_d = S_IDLE;
        else if (|abort_set) st_d = S_STOP;
        else begin
          case (st_q)
            S_START, S_RSTART: st_d = S_A1;
            S_A1:   st_d = ten ? S_A2 : S_DATA;
            S_A2:   st_d = rd_q ? S_RS10 : S_DATA;
            S_RS10: st_d = S_A3;
            S_A3:   st_d = S_DATA;
            S_DATA: st_d = head.stp ? S_STOP : S_HOLD;
            default: st_d = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      rd_q  <= 1'b0;
      tgt_q <= '0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
      if (xfer_begin) tgt_q <= tgt_addr;
    end
  end

  AST_ARB_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && prim_arb_lost) |=> !prim_req); // R10
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && prim_nack && !prim_arb_lost && (st_q inside {S_A1, S_A2, S_A3}))
      |=> (prim_req && prim_op == P_STOP)); // R9
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !tx_has && enable) |=> !prim_req); // R7
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 4,
  parameter int EN_DLY   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enable,
  input  logic [12:0]                     tgt_addr,
  input  logic                            cmd_push,
  input  logic [10:0]                     cmd_word,
  input  logic                            rx_pop,
  output logic [7:0]                      rx_data,
  output logic [$clog2(TX_DEPTH+1)-1:0]   tx_level,
  output logic [$clog2(RX_DEPTH+1)-1:0]   rx_level,
  output logic                            en_status,
  output logic                            activity,
  output logic                            scl_hold,
  output logic [12:0]                     abort_src,
  output logic                            prim_req,
  output logic [2:0]                      prim_op,
  output logic [7:0]                      prim_byte,
  input  logic                            prim_done,
  input  logic                            prim_nack,
  input  logic                            prim_arb_lost,
  input  logic [7:0]                      prim_rdata
);
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_full, rx_empty;
  logic [CMD_W-1:0]  head_raw;
  cmd_t              head;
  logic [ABRT_W-1:0] fsm_abort, abort_all;
  logic              xfer_begin, flush, off_push;

  assign off_push = cmd_push && !en_status;
  assign tx_push  = cmd_push && en_status;
  assign head     = cmd_t'(head_raw);

  always_comb begin
    abort_all = fsm_abort;
    if (off_push) abort_all[AB_OFF] = 1'b1;
  end
  assign flush = |abort_all;

  i2cs_fifo #(.DW(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push), .wdata(cmd_word), .pop(tx_pop), .rdata(head_raw),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  i2cs_fifo #(.DW(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .wdata(prim_rdata), .pop(rx_pop), .rdata(rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  i2cs_en_sync #(.DLY(EN_DLY)) u_en (
    .clk(clk), .rst_n(rst_n), .enable(enable), .busy(activity), .en_status(en_status)
  );

  i2cs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .en_live(en_status),
    .tgt_addr(tgt_addr), .head(head), .tx_has(!tx_empty), .rx_full(rx_full),
    .prim_done(prim_done), .prim_nack(prim_nack), .prim_arb_lost(prim_arb_lost),
    .prim_req(prim_req), .prim_op(prim_op), .prim_byte(prim_byte),
    .tx_pop(tx_pop), .rx_push(rx_push), .abort_set(fsm_abort),
    .xfer_begin(xfer_begin), .busy(activity), .hold(scl_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          abort_src <= '0;
    else if (xfer_begin) abort_src <= abort_all;
    else                 abort_src <= abort_src | abort_all;
  end

  AST_FLUSH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_level == '0 && rx_level == '0)); // R12
  AST_OFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    off_push |=> (abort_src[AB_OFF] && tx_level == '0)); // R11
  AST_BEGIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |=> (abort_src == '0)); // R12
endmodule

// File: tb/test_i2c_cmd_seq.sv
module test_i2c_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int EN_DLY = 4;
  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_ADDR = 3'd2,
                         OP_WRITE = 3'd3, OP_READ = 3'd4, OP_STOP = 3'd5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, enable, cmd_push, rx_pop, prim_done, prim_nack, prim_arb_lost;
  logic [12:0] tgt_addr, abort_src;
  logic [10:0] cmd_word;
  logic [7:0]  rx_data, prim_byte, prim_rdata;
  logic [3:0]  tx_level;
  logic [2:0]  rx_level, prim_op;
  logic        en_status, activity, scl_hold, prim_req;

  i2c_cmd_seq #(.TX_DEPTH(8), .RX_DEPTH(4), .EN_DLY(EN_DLY)) i_i2c_cmd_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tgt_addr(tgt_addr),
    .cmd_push(cmd_push), .cmd_word(cmd_word), .rx_pop(rx_pop), .rx_data(rx_data),
    .tx_level(tx_level), .rx_level(rx_level), .en_status(en_status),
    .activity(activity), .scl_hold(scl_hold), .abort_src(abort_src),
    .prim_req(prim_req), .prim_op(prim_op), .prim_byte(prim_byte),
    .prim_done(prim_done), .prim_nack(prim_nack), .prim_arb_lost(prim_arb_lost),
    .prim_rdata(prim_rdata)
  );

  int checks = 0, errors = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  int  seen = 0, nack_at = -1, arb_at = -1, rd_cnt = 0;
  logic [7:0] rd_base = 8'h00;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_prim(input logic [2:0] op, input logic [7:0] b, input string req);
    exp_q.push_back({op, b});
    tag_q.push_back(req);
  endtask

  task automatic arm(input int n, input int a, input logic [7:0] base);
    seen = 0; nack_at = n; arb_at = a; rd_base = base; rd_cnt = 0;
  endtask

  task automatic push_cmd(input bit rs, input bit stp, input bit rd, input logic [7:0] d);
    @(negedge clk);
    cmd_word = {rs, stp, rd, d};
    cmd_push = 1'b1;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!activity && exp_q.size() == 0) break;
    end
    chk(!activity, req, "bus released", activity, 0);
    chk(exp_q.size() == 0, req, "all primitives seen", exp_q.size(), 0);
  endtask

  task automatic wait_hold(input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (scl_hold) break;
    end
    chk(scl_hold, req, "hold reached", scl_hold, 1);
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(rx_data == exp, req, "rx byte", rx_data, exp);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic wait_en(input bit v);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (en_status == v) break;
    end
  endtask

  // bit-engine model and primitive scoreboard monitor
  initial begin
    logic [10:0] got, e;
    string t;
    prim_done = 0; prim_nack = 0; prim_arb_lost = 0; prim_rdata = 0;
    forever begin
      @(negedge clk);
      if (prim_req) begin
        @(negedge clk);
        got = {prim_op, prim_byte};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected primitive", got, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, "primitive {op,byte}", got, e);
        end
        prim_nack     = (seen == nack_at);
        prim_arb_lost = (seen == arb_at);
        if (prim_op == OP_READ) begin
          prim_rdata = rd_base + 8'(rd_cnt);
          rd_cnt++;
        end
        seen++;
        prim_done = 1'b1;
        @(negedge clk);
        prim_done = 1'b0; prim_nack = 1'b0; prim_arb_lost = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; tgt_addr = 13'h0050; cmd_push = 0; cmd_word = 0; rx_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx_level == 0 && rx_level == 0, "R1", "levels", {tx_level, rx_level}, 0);
    chk(!en_status && !activity && !scl_hold && !prim_req, "R1", "status",
        {en_status, activity, scl_hold, prim_req}, 0);
    chk(abort_src == 0, "R1", "abort_src", abort_src, 0);

    // R2 enable delay
    enable = 1'b1;
    repeat (EN_DLY) @(negedge clk);
    chk(!en_status, "R2", "en_status before delay", en_status, 0);
    @(negedge clk);
    chk(en_status, "R2", "en_status after delay", en_status, 1);

    // R4 R7: 7-bit write with an empty-queue hold
    arm(-1, -1, 8'h00);
    tgt_addr = 13'h0050;
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R4");
    expect_prim(OP_WRITE, 8'h3C, "R3");
    push_cmd(0, 0, 0, 8'h3C);
    wait_hold("R7");
    repeat (3) @(negedge clk);
    chk(scl_hold && activity && !prim_req, "R7", "holding quietly",
        {scl_hold, activity, prim_req}, 3'b110);
    chk(exp_q.size() == 0, "R7", "nothing pending", exp_q.size(), 0);
    expect_prim(OP_WRITE, 8'hC3, "R7");
    expect_prim(OP_STOP, 8'h00, "R3");
    push_cmd(0, 1, 0, 8'hC3);
    wait_idle("R4");
    chk(tx_level == 0 && abort_src == 0, "R8", "clean finish", {tx_level, abort_src}, 0);

    // R6 R8: write then read without restart flag
    arm(-1, -1, 8'h5A);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R4");
    expect_prim(OP_WRITE, 8'h11, "R3");
    expect_prim(OP_RSTART, 8'h00, "R6");
    expect_prim(OP_ADDR, 8'hA1, "R6");
    expect_prim(OP_READ, 8'h01, "R3");
    expect_prim(OP_STOP, 8'h00, "R3");
    push_cmd(0, 0, 0, 8'h11);
    push_cmd(0, 1, 1, 8'h00);
    wait_idle("R6");
    chk(rx_level == 1, "R8", "rx_level", rx_level, 1);
    pop_rx(8'h5A, "R8");

    // R6: restart flag, same direction
    arm(-1, -1, 8'h00);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R4");
    expect_prim(OP_WRITE, 8'h01, "R6");
    expect_prim(OP_RSTART, 8'h00, "R6");
    expect_prim(OP_ADDR, 8'hA0, "R6");
    expect_prim(OP_WRITE, 8'h02, "R6");
    expect_prim(OP_STOP, 8'h00, "R6");
    push_cmd(0, 0, 0, 8'h01);
    push_cmd(1, 1, 0, 8'h02);
    wait_idle("R6");

    // R5: 10-bit write
    arm(-1, -1, 8'h00);
    tgt_addr = 13'h12A5;
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hF4, "R5");
    expect_prim(OP_ADDR, 8'hA5, "R5");
    expect_prim(OP_WRITE, 8'h77, "R5");
    expect_prim(OP_STOP, 8'h00, "R5");
    push_cmd(0, 1, 0, 8'h77);
    wait_idle("R5");

    // R5 R8: 10-bit two-byte read
    arm(-1, -1, 8'h90);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hF4, "R5");
    expect_prim(OP_ADDR, 8'hA5, "R5");
    expect_prim(OP_RSTART, 8'h00, "R5");
    expect_prim(OP_ADDR, 8'hF5, "R5");
    expect_prim(OP_READ, 8'h00, "R5");
    expect_prim(OP_READ, 8'h01, "R3");
    expect_prim(OP_STOP, 8'h00, "R5");
    push_cmd(0, 0, 1, 8'h00);
    push_cmd(0, 1, 1, 8'h00);
    wait_idle("R5");
    chk(rx_level == 2, "R8", "rx_level two reads", rx_level, 2);
    pop_rx(8'h90, "R8");
    pop_rx(8'h91, "R8");

    // R9 R12: 7-bit address NACK flushes queued commands
    arm(1, -1, 8'h00);
    tgt_addr = 13'h0050;
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R9");
    expect_prim(OP_STOP, 8'h00, "R9");
    push_cmd(0, 0, 0, 8'hA1);
    push_cmd(0, 0, 0, 8'hA2);
    push_cmd(0, 0, 0, 8'hA3);
    wait_idle("R9");
    chk(abort_src == 13'h0001, "R9", "7-bit address nack bit", abort_src, 13'h0001);
    chk(tx_level == 0, "R12", "tx flushed", tx_level, 0);

    // R9 R12: data NACK after a read, rx flushed, old abort cleared
    arm(5, -1, 8'h33);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA1, "R4");
    expect_prim(OP_READ, 8'h00, "R3");
    expect_prim(OP_RSTART, 8'h00, "R6");
    expect_prim(OP_ADDR, 8'hA0, "R6");
    expect_prim(OP_WRITE, 8'h99, "R9");
    expect_prim(OP_STOP, 8'h00, "R9");
    push_cmd(0, 0, 1, 8'h00);
    push_cmd(0, 1, 0, 8'h99);
    wait_idle("R9");
    chk(abort_src == 13'h0008, "R12", "data nack only (old cleared)", abort_src, 13'h0008);
    chk(rx_level == 0, "R12", "rx flushed", rx_level, 0);

    // R9: first 10-bit byte NACK
    arm(1, -1, 8'h00);
    tgt_addr = 13'h12A5;
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hF4, "R9");
    expect_prim(OP_STOP, 8'h00, "R9");
    push_cmd(0, 1, 0, 8'h10);
    wait_idle("R9");
    chk(abort_src == 13'h0002, "R9", "10-bit first byte nack", abort_src, 13'h0002);

    // R9: second 10-bit byte NACK
    arm(2, -1, 8'h00);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hF4, "R5");
    expect_prim(OP_ADDR, 8'hA5, "R9");
    expect_prim(OP_STOP, 8'h00, "R9");
    push_cmd(0, 1, 0, 8'h20);
    wait_idle("R9");
    chk(abort_src == 13'h0004, "R9", "10-bit second byte nack", abort_src, 13'h0004);

    // R10: arbitration lost, no stop
    arm(-1, 2, 8'h00);
    tgt_addr = 13'h0050;
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R4");
    expect_prim(OP_WRITE, 8'h44, "R10");
    push_cmd(0, 0, 0, 8'h44);
    push_cmd(0, 1, 0, 8'h45);
    wait_idle("R10");
    repeat (4) @(negedge clk);
    chk(!prim_req && !activity, "R10", "no stop after arb loss", {prim_req, activity}, 0);
    chk(abort_src == 13'h1000, "R10", "arb bit", abort_src, 13'h1000);
    chk(tx_level == 0, "R12", "tx flushed after arb", tx_level, 0);

    // R13 R2: disable while holding
    arm(-1, -1, 8'h00);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R4");
    expect_prim(OP_WRITE, 8'h55, "R13");
    push_cmd(0, 0, 0, 8'h55);
    wait_hold("R13");
    expect_prim(OP_STOP, 8'h00, "R13");
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(en_status, "R2", "en_status lags disable", en_status, 1);
    wait_idle("R13");
    wait_en(1'b0);
    chk(!en_status, "R2", "en_status drops when idle", en_status, 0);

    // R11: command while disabled
    push_cmd(0, 1, 0, 8'h66);
    repeat (2) @(negedge clk);
    chk(abort_src == 13'h0800, "R11", "disabled push bit", abort_src, 13'h0800);
    chk(tx_level == 0 && !prim_req && !activity, "R11", "entry dropped",
        {tx_level, prim_req, activity}, 0);

    // R12: next transfer clears abort_src
    enable = 1'b1;
    wait_en(1'b1);
    arm(-1, -1, 8'h00);
    expect_prim(OP_START, 8'h00, "R4");
    expect_prim(OP_ADDR, 8'hA0, "R4");
    expect_prim(OP_WRITE, 8'h01, "R3");
    expect_prim(OP_STOP, 8'h00, "R3");
    push_cmd(0, 1, 0, 8'h01);
    wait_idle("R12");
    chk(abort_src == 0, "R12", "abort cleared by new start", abort_src, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule